// File: doc/BRIEF.md
# IDE Controller Configuration Register File

This block holds the 256-byte configuration space of a dual-channel IDE host controller. A host-side agent reads and writes it one byte at a time, using a function number and a byte address. Each implemented byte applies its own write rule. A byte may take only some of the written bits, may keep some of its stored bits, may clear the bits written as one, or may accept a write only while a gating bit elsewhere in the space is set. Reads are combinational. They return the stored byte, the byte from one of two external bus-master register ports, or all ones when the function number is not zero.

The decoded configuration is driven out as plain buses for the channel decoder and the interrupt logic. These buses are the command byte, the programming interface, the channel control byte, the four task-file base registers and the two bus-master base addresses. Two variants are selected by parameter: the base part and the enhanced part. They differ in their identity, their reset defaults and several write masks. A second parameter gives the programming-interface byte that is loaded at reset, and that byte decides whether the base registers come up native and writable.

Top module: `ide_cfg_regfile`

## Requirements
- R1: After reset the space reads vendor 0x1095 at 0x00, device 0x0646 (0x0648 enhanced) at 0x02, status 0x0280 at 0x06, the reset programming interface at 0x09, 0x01 at both 0x0A and 0x0B, interrupt line 0x0E at 0x3C and pin 0x01 at 0x3D. 0x51 resets to 0x08 (0x0C enhanced) and 0x57 to 0x0C. When the reset programming interface has all of bits 0x8A set, 0x50 resets to 0x40 and the base registers at 0x10/0x14/0x18/0x1C reset to 0x01F1, 0x03F5, 0x0171 and 0x0375. Otherwise those bytes reset to zero.
- R2: A write to 0x04 stores only the written bits 0x45.
- R3: Event inputs set bits of 0x07 within 0xB1. A write to 0x07 clears the bits written as one within mask 0xB1 and leaves every other bit unchanged.
- R4: The base-register bytes 0x10-0x1D accept writes only while bit 6 of 0x50 is set. Low bytes 0x10/0x18 store (value & 0xF8) | 1, low bytes 0x14/0x1C store (value & 0xFC) | 1, and the high bytes store the value unchanged.
- R5: A write to 0x20 stores (value & 0xF0) | 1. The channel 0 bus-master base is {0x21, 0x20 & 0xF0}, and the channel 1 base is that value plus 8.
- R6: A write to 0x09 takes effect only while bits 1 and 3 of 0x09 are both set, and in the enhanced variant only while 0x0A and 0x0B both hold 0x01. An accepted write changes only bits 0 and 2 and keeps bits 0x8A.
- R7: 0x51 stores the written bits 0xC8 (0xCC enhanced). 0x53 and 0x55 store only bits 0xC0. 0x57 keeps its bit 4 and takes the written bits 0xCC.
- R8: 0x0A and 0x0B are writable only in the enhanced variant, and only while bit 2 of 0x4F is set.
- R9: Addresses 0x70-0x77 go to bus-master port 0 and 0x78-0x7F go to port 1, with the offset taken from address bits 2:0. Writes raise the matching write strobe, and reads return that port's data. In the base variant the data written to offset 1 is masked to bits 0x03.
- R10: With a function number other than 0, reads return 0xFF and writes change nothing.
- R11: Unimplemented addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 3 | Function number of the access |
| addr_i | input | 8 | Byte address for reads and writes |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| stat_evt_i | input | 8 | Status event pulses that set bits of byte 0x07 |
| bm_we_o | output | 2 | Per-channel bus-master write strobe |
| bm_off_o | output | 3 | Bus-master register offset |
| bm_wdata_o | output | 8 | Bus-master write data |
| bm_rdata0_i | input | 8 | Channel 0 bus-master read data |
| bm_rdata1_i | input | 8 | Channel 1 bus-master read data |
| cmd_o | output | 8 | Command byte |
| prog_if_o | output | 8 | Programming interface byte |
| chan_ctl_o | output | 8 | Channel control byte 0x51 |
| bar_o | output | 64 | Four 16-bit task-file base registers, base 0 in bits 15:0 |
| bm_base_o | output | 32 | Bus-master bases, channel 0 in bits 15:0 |

## Verification
The assertions assume that function number, address, write strobe and data are stable around each rising edge, and that a write and a status event are never aimed at byte 0x07 in the same cycle. The bench meets these assumptions by changing inputs only on falling edges and by issuing events and writes in separate tasks. One instance of each variant is driven from the same bus. The enhanced instance is reset with a programming interface that leaves the base registers locked, so that the lock paths are exercised.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    localparam int CFG_BYTES = 256;
    localparam int BM_CH     = 2;
    localparam int BM_STRIDE = 8;
    localparam int BAR_N     = 4;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  take;
        byte_t val;
    } wr_res_t;

    typedef struct packed {
        logic bar_unlock;
        logic class_unlock;
        logic pif_open;
    } gate_t;

    localparam byte_t A_CMD    = 8'h04;
    localparam byte_t A_STAT   = 8'h07;
    localparam byte_t A_PIF    = 8'h09;
    localparam byte_t A_SUBCL  = 8'h0A;
    localparam byte_t A_CLASS  = 8'h0B;
    localparam byte_t A_BAR0   = 8'h10;
    localparam byte_t A_BMB_LO = 8'h20;
    localparam byte_t A_BMB_HI = 8'h21;
    localparam byte_t A_VCTL   = 8'h4F;
    localparam byte_t A_BAREN  = 8'h50;
    localparam byte_t A_CHCTL  = 8'h51;

    localparam byte_t STAT_W1C = 8'hB1;
    localparam byte_t PIF_KEEP = 8'h8A;
    localparam byte_t PIF_TAKE = 8'h05;

    function automatic byte_t reset_byte(byte_t a, bit enh, byte_t pif);
        byte_t r;
        logic  native;
        native = ((pif & PIF_KEEP) == PIF_KEEP);
        r = 8'h00;
        case (a)
            8'h00, 8'h2C: r = (a == 8'h00 || enh) ? 8'h95 : 8'h00;
            8'h01, 8'h2D: r = (a == 8'h01 || enh) ? 8'h10 : 8'h00;
            8'h02, 8'h2E: r = (a == 8'h02 || enh) ? (enh ? 8'h48 : 8'h46) : 8'h00;
            8'h03, 8'h2F: r = (a == 8'h03 || enh) ? 8'h06 : 8'h00;
            8'h06: r = 8'h80;
            8'h07: r = 8'h02;
            8'h09: r = pif;
            8'h0A, 8'h0B: r = 8'h01;
            8'h20: r = 8'h01;
            8'h3C: r = 8'h0E;
            8'h3D: r = 8'h01;
            8'h3E: r = 8'h02;
            8'h3F: r = 8'h04;
            8'h51: r = enh ? 8'h0C : 8'h08;
            8'h57: r = 8'h0C;
            8'h59: r = enh ? 8'h00 : 8'h40;
            8'h34: r = enh ? 8'h60 : 8'h00;
            8'h60: r = enh ? 8'h01 : 8'h00;
            8'h62: r = enh ? 8'h21 : 8'h00;
            8'h63: r = enh ? 8'h06 : 8'h00;
            8'h65: r = enh ? 8'h60 : 8'h00;
            8'h67: r = enh ? 8'hF0 : 8'h00;
            8'h50: r = native ? 8'h40 : 8'h00;
            8'h10: r = native ? 8'hF1 : 8'h00;
            8'h11: r = native ? 8'h01 : 8'h00;
            8'h14: r = native ? 8'hF5 : 8'h00;
            8'h15: r = native ? 8'h03 : 8'h00;
            8'h18: r = native ? 8'h71 : 8'h00;
            8'h19: r = native ? 8'h01 : 8'h00;
            8'h1C: r = native ? 8'h75 : 8'h00;
            8'h1D: r = native ? 8'h03 : 8'h00;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic wr_res_t next_byte(byte_t a, byte_t old, byte_t v, bit enh, gate_t g);
        wr_res_t r;
        r.take = 1'b0;
        r.val  = old;
        case (a)
            A_CMD:    begin r.take = 1'b1; r.val = v & 8'h45; end
            A_STAT:   begin r.take = 1'b1; r.val = old & ~(v & STAT_W1C); end
            A_PIF:    begin r.take = g.pif_open; r.val = (old & PIF_KEEP) | (v & PIF_TAKE); end
            A_SUBCL, A_CLASS: begin r.take = enh && g.class_unlock; r.val = v; end
            8'h10, 8'h18: begin r.take = g.bar_unlock; r.val = (v & 8'hF8) | 8'h01; end
            8'h14, 8'h1C: begin r.take = g.bar_unlock; r.val = (v & 8'hFC) | 8'h01; end
            8'h11, 8'h15, 8'h19, 8'h1D: begin r.take = g.bar_unlock; r.val = v; end
            A_BMB_LO: begin r.take = 1'b1; r.val = (v & 8'hF0) | 8'h01; end
            A_BMB_HI: begin r.take = 1'b1; r.val = v; end
            8'h2C, 8'h2D, 8'h2E, 8'h2F: begin r.take = enh; r.val = v; end
            8'h3C:    begin r.take = 1'b1; r.val = v; end
            A_VCTL:   begin r.take = enh; r.val = (old & 8'hFA) | (v & 8'h05); end
            A_CHCTL:  begin r.take = 1'b1; r.val = v & (enh ? 8'hCC : 8'hC8); end
            8'h52, 8'h54, 8'h56, 8'h58, 8'h5B: begin r.take = 1'b1; r.val = v; end
            8'h59:    begin r.take = !enh; r.val = v; end
            8'h53, 8'h55: begin r.take = 1'b1; r.val = v & 8'hC0; end
            8'h57:    begin r.take = 1'b1; r.val = (old & 8'h10) | (v & 8'hCC); end
            8'h64:    begin r.take = enh; r.val = (old & 8'hFC) | (v & 8'h03); end
            8'h65:    begin r.take = enh; r.val = (old & 8'h7F) | (v & 8'h80); end
            default:  begin r.take = 1'b0; r.val = old; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ide_cfg_wr_ctl.sv
module ide_cfg_wr_ctl
    import ide_cfg_pkg::*;
#(
    parameter bit ENHANCED = 1'b0
) (
    input  logic  we_i,
    input  byte_t addr_i,
    input  byte_t old_i,
    input  byte_t wdata_i,
    input  gate_t gate_i,
    output logic  take_o,
    output byte_t val_o
);
    wr_res_t res;

    always_comb begin
        res    = next_byte(addr_i, old_i, wdata_i, ENHANCED, gate_i);
        take_o = we_i && res.take;
        val_o  = res.val;
    end

    always_comb begin
        if (take_o && (addr_i == A_CMD)) begin
            assert ((val_o & ~8'h45) == 8'h00)
                else $error("p_cmd_mask_r2: command write carries masked bits");
        end
    end
endmodule

// File: rtl/ide_cfg_bm_route.sv
module ide_cfg_bm_route
    import ide_cfg_pkg::*;
#(
    parameter bit ENHANCED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  byte_t             addr_i,
    input  byte_t             wdata_i,
    input  byte_t             rdata0_i,
    input  byte_t             rdata1_i,
    output logic              hit_o,
    output byte_t             rdata_o,
    output logic [BM_CH-1:0]  we_o,
    output logic [2:0]        off_o,
    output byte_t             wdata_o
);
    localparam int OFF_W = $clog2(BM_STRIDE);

    logic ch;

    assign hit_o   = (addr_i[7:4] == 4'h7);
    assign ch      = addr_i[OFF_W];
    assign off_o   = addr_i[OFF_W-1:0];
    assign rdata_o = ch ? rdata1_i : rdata0_i;

    for (genvar c = 0; c < BM_CH; c++) begin : g_we
        assign we_o[c] = wr_i && hit_o && (ch == c[0]);
    end

    if (ENHANCED) begin : g_full
        assign wdata_o = wdata_i;
    end else begin : g_mask
        assign wdata_o = (off_o == 3'd1) ? (wdata_i & 8'h03) : wdata_i;
    end

    p_bm_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_o));
    p_bm_nostrobe_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_i |-> (we_o == '0));
endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
    import ide_cfg_pkg::*;
#(
    parameter bit         ENHANCED = 1'b0,
    parameter logic [7:0] PIF_RST  = 8'h8A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  func_i,
    input  logic [7:0]  addr_i,
    input  logic        wr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic [7:0]  stat_evt_i,
    output logic [1:0]  bm_we_o,
    output logic [2:0]  bm_off_o,
    output logic [7:0]  bm_wdata_o,
    input  logic [7:0]  bm_rdata0_i,
    input  logic [7:0]  bm_rdata1_i,
    output logic [7:0]  cmd_o,
    output logic [7:0]  prog_if_o,
    output logic [7:0]  chan_ctl_o,
    output logic [63:0] bar_o,
    output logic [31:0] bm_base_o
);
    byte_t regs [CFG_BYTES];

    logic  wr0;
    gate_t gate;
    logic  take;
    byte_t wval;
    byte_t stat_next;
    logic  bm_hit;
    byte_t bm_rd;
    logic [15:0] bm_base;

    assign wr0 = wr_i && (func_i == 3'd0);

    always_comb begin
        gate.bar_unlock   = regs[A_BAREN][6];
        gate.class_unlock = regs[A_VCTL][2];
        gate.pif_open     = regs[A_PIF][1] && regs[A_PIF][3] &&
                            (!ENHANCED || (regs[A_SUBCL] == 8'h01 && regs[A_CLASS] == 8'h01));
    end

    ide_cfg_wr_ctl #(.ENHANCED(ENHANCED)) u_wr (
        .we_i    (wr0),
        .addr_i  (addr_i),
        .old_i   (regs[addr_i]),
        .wdata_i (wdata_i),
        .gate_i  (gate),
        .take_o  (take),
        .val_o   (wval)
    );

    ide_cfg_bm_route #(.ENHANCED(ENHANCED)) u_bm (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr0),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata0_i (bm_rdata0_i),
        .rdata1_i (bm_rdata1_i),
        .hit_o    (bm_hit),
        .rdata_o  (bm_rd),
        .we_o     (bm_we_o),
        .off_o    (bm_off_o),
        .wdata_o  (bm_wdata_o)
    );

    always_comb begin
        stat_next = (take && addr_i == A_STAT) ? wval : regs[A_STAT];
        stat_next = stat_next | (stat_evt_i & STAT_W1C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++) begin
                regs[i] <= reset_byte(byte_t'(i), ENHANCED, PIF_RST);
            end
        end else begin
            if (take) begin
                regs[addr_i] <= wval;
            end
            regs[A_STAT] <= stat_next;
        end
    end

    always_comb begin
        if (func_i != 3'd0) begin
            rdata_o = 8'hFF;
        end else if (bm_hit) begin
            rdata_o = bm_rd;
        end else begin
            rdata_o = regs[addr_i];
        end
    end

    assign cmd_o      = regs[A_CMD];
    assign prog_if_o  = regs[A_PIF];
    assign chan_ctl_o = regs[A_CHCTL];
    assign bm_base    = {regs[A_BMB_HI], regs[A_BMB_LO] & 8'hF0};

    for (genvar k = 0; k < BAR_N; k++) begin : g_bar
        localparam byte_t LO = byte_t'(A_BAR0 + 8'(4 * k));
        localparam byte_t HI = byte_t'(LO + 8'd1);
        assign bar_o[16*k +: 16] = {regs[HI], regs[LO]};
    end

    for (genvar c = 0; c < BM_CH; c++) begin : g_bmb
        assign bm_base_o[16*c +: 16] = bm_base + 16'(BM_STRIDE * c);
    end

    p_cmd_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr0 && addr_i == A_CMD) |=> (cmd_o == ($past(wdata_i) & 8'h45)));
    p_bar_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (wr0 && addr_i == A_BAR0 && !regs[A_BAREN][6]) |=> $stable(bar_o[15:0]));
    p_bar_bit0_r4: assert property (@(posedge clk) disable iff (rst)
        (wr0 && addr_i == A_BAR0 && regs[A_BAREN][6]) |=> bar_o[0]);
    p_bmbase_low_r5: assert property (@(posedge clk) disable iff (rst)
        (wr0 && addr_i == A_BMB_LO) |=> (regs[A_BMB_LO][3:0] == 4'h1));
    p_pif_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (wr0 && addr_i == A_PIF) |=> ((prog_if_o & PIF_KEEP) == ($past(prog_if_o) & PIF_KEEP)));
    p_func_ff_r10: assert property (@(posedge clk) disable iff (rst)
        (func_i != 3'd0) |-> (rdata_o == 8'hFF));
    p_func_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_i && func_i != 3'd0) |=> $stable(cmd_o));
endmodule

// File: tb/tb_ide_cfg_regfile.sv
module tb_ide_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  func_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  stat_evt_i = '0;
    logic [7:0]  bm_rdata0_i = 8'hA5;
    logic [7:0]  bm_rdata1_i = 8'h5A;

    logic [7:0]  rdata_b, rdata_e;
    logic [1:0]  bm_we_b, bm_we_e;
    logic [2:0]  bm_off_b, bm_off_e;
    logic [7:0]  bm_wd_b, bm_wd_e;
    logic [7:0]  cmd_b, cmd_e, pif_b, pif_e, chc_b, chc_e;
    logic [63:0] bar_b, bar_e;
    logic [31:0] bmb_b, bmb_e;

    int tests = 0;
    int fails = 0;
    int refm [256];
    bit live = 1'b0;

    always #10 clk = ~clk;

    ide_cfg_regfile #(.ENHANCED(1'b0), .PIF_RST(8'h8A)) dut (
        .clk(clk), .rst(rst), .func_i(func_i), .addr_i(addr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_b), .stat_evt_i(stat_evt_i),
        .bm_we_o(bm_we_b), .bm_off_o(bm_off_b), .bm_wdata_o(bm_wd_b),
        .bm_rdata0_i(bm_rdata0_i), .bm_rdata1_i(bm_rdata1_i),
        .cmd_o(cmd_b), .prog_if_o(pif_b), .chan_ctl_o(chc_b),
        .bar_o(bar_b), .bm_base_o(bmb_b));

    ide_cfg_regfile #(.ENHANCED(1'b1), .PIF_RST(8'h80)) dut_e (
        .clk(clk), .rst(rst), .func_i(func_i), .addr_i(addr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_e), .stat_evt_i(stat_evt_i),
        .bm_we_o(bm_we_e), .bm_off_o(bm_off_e), .bm_wdata_o(bm_wd_e),
        .bm_rdata0_i(bm_rdata0_i), .bm_rdata1_i(bm_rdata1_i),
        .cmd_o(cmd_e), .prog_if_o(pif_e), .chan_ctl_o(chc_e),
        .bar_o(bar_e), .bm_base_o(bmb_e));

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Base-variant reference model built from the requirements.
    function automatic void model_reset();
        for (int i = 0; i < 256; i++) refm[i] = 0;
        refm[8'h00] = 8'h95; refm[8'h01] = 8'h10; refm[8'h02] = 8'h46; refm[8'h03] = 8'h06;
        refm[8'h06] = 8'h80; refm[8'h07] = 8'h02; refm[8'h09] = 8'h8A;
        refm[8'h0A] = 8'h01; refm[8'h0B] = 8'h01; refm[8'h20] = 8'h01;
        refm[8'h3C] = 8'h0E; refm[8'h3D] = 8'h01; refm[8'h3E] = 8'h02; refm[8'h3F] = 8'h04;
        refm[8'h51] = 8'h08; refm[8'h57] = 8'h0C; refm[8'h59] = 8'h40; refm[8'h50] = 8'h40;
        refm[8'h10] = 8'hF1; refm[8'h11] = 8'h01; refm[8'h14] = 8'hF5; refm[8'h15] = 8'h03;
        refm[8'h18] = 8'h71; refm[8'h19] = 8'h01; refm[8'h1C] = 8'h75; refm[8'h1D] = 8'h03;
    endfunction

    function automatic void model_write(int a, int v);
        bit unl = refm[8'h50][6];
        case (a)
            8'h04: refm[a] = v & 8'h45;
            8'h07: refm[a] = refm[a] & ~(v & 8'hB1);
            8'h09: if ((refm[a] & 8'h0A) == 8'h0A) refm[a] = (refm[a] & 8'h8A) | (v & 8'h05);
            8'h10, 8'h18: if (unl) refm[a] = (v & 8'hF8) | 1;
            8'h14, 8'h1C: if (unl) refm[a] = (v & 8'hFC) | 1;
            8'h11, 8'h15, 8'h19, 8'h1D: if (unl) refm[a] = v;
            8'h20: refm[a] = (v & 8'hF0) | 1;
            8'h21, 8'h3C, 8'h52, 8'h54, 8'h56, 8'h58, 8'h59, 8'h5B: refm[a] = v;
            8'h51: refm[a] = v & 8'hC8;
            8'h53, 8'h55: refm[a] = v & 8'hC0;
            8'h57: refm[a] = (refm[a] & 8'h10) | (v & 8'hCC);
            default: ;
        endcase
    endfunction

    task automatic wr(int a, int v, int fn = 0);
        @(negedge clk);
        addr_i = 8'(a); wdata_i = 8'(v); func_i = 3'(fn); wr_i = 1'b1;
        @(posedge clk);
        #1;
        if (fn == 0) model_write(a, v);
        wr_i = 1'b0; func_i = '0;
    endtask

    task automatic rd(int a, output int rb, output int re, input int fn = 0);
        @(negedge clk);
        addr_i = 8'(a); func_i = 3'(fn);
        #2;
        rb = rdata_b; re = rdata_e;
        func_i = '0;
    endtask

    task automatic check_space(string tag);
        int rb, re;
        for (int a = 0; a < 256; a++) begin
            if (a < 8'h70 || a > 8'h7F) begin
                rd(a, rb, re);
                check(tag, rb, refm[a]);
            end
        end
    endtask

    // Continuous comparison of the decoded outputs with the model.
    always @(negedge clk) begin
        if (live) begin
            check("R2 cmd_o", cmd_b, refm[8'h04]);
            check("R6 prog_if_o", pif_b, refm[8'h09]);
            check("R7 chan_ctl_o", chc_b, refm[8'h51]);
            check("R4 bar_o", bar_b, {refm[8'h1D][7:0], refm[8'h1C][7:0], refm[8'h19][7:0],
                  refm[8'h18][7:0], refm[8'h15][7:0], refm[8'h14][7:0],
                  refm[8'h11][7:0], refm[8'h10][7:0]});
            check("R5 bm_base_o", bmb_b,
                  {16'({refm[8'h21][7:0], refm[8'h20][7:4], 4'h0} + 8),
                   refm[8'h21][7:0], refm[8'h20][7:4], 4'h0});
        end
    end

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rb, re;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        live = 1'b1;

        // R1 reset state of the whole space, base variant
        check_space("R1 reset");
        // R1 enhanced identity and locked defaults
        rd(8'h02, rb, re); check("R1 enh device", re, 8'h48);
        rd(8'h51, rb, re); check("R1 enh 0x51", re, 8'h0C);
        rd(8'h50, rb, re); check("R1 enh 0x50 locked", re, 8'h00);
        check("R1 enh bars", int'(bar_e[31:0]), 0);

        // R2 command mask
        wr(8'h04, 8'hFF); rd(8'h04, rb, re); check("R2 cmd", rb, refm[8'h04]);
        wr(8'h04, 8'h00);

        // R3 status events and write-one-to-clear
        @(negedge clk); stat_evt_i = 8'hFF;
        @(posedge clk); #1 stat_evt_i = 8'h00; refm[8'h07] |= 8'hB1;
        rd(8'h07, rb, re); check("R3 set", rb, 8'hB3);
        wr(8'h07, 8'h13); rd(8'h07, rb, re); check("R3 w1c", rb, 8'hA2);
        wr(8'h07, 8'hFF); rd(8'h07, rb, re); check("R3 keep bit1", rb, 8'h02);

        // R4 base registers (unlocked in base, locked in enhanced)
        wr(8'h10, 8'h37); rd(8'h10, rb, re); check("R4 lo F8", rb, 8'h31);
        check("R4 locked enh", re, 8'h00);
        wr(8'h14, 8'h37); rd(8'h14, rb, re); check("R4 lo FC", rb, 8'h35);
        wr(8'h19, 8'hAB); rd(8'h19, rb, re); check("R4 hi", rb, 8'hAB);
        wr(8'h1C, 8'h00); rd(8'h1C, rb, re); check("R4 bit0", rb, 8'h01);

        // R5 bus-master base
        wr(8'h20, 8'hFF); rd(8'h20, rb, re); check("R5 lo", rb, 8'hF1);
        wr(8'h21, 8'h12);
        @(negedge clk); check("R5 ch1", int'(bmb_b[31:16]), 16'h12F8);
        check("R5 ch0", int'(bmb_b[15:0]), 16'h12F0);

        // R6 programming interface lock
        wr(8'h09, 8'hFF); rd(8'h09, rb, re); check("R6 open", rb, 8'h8F);
        check("R6 locked enh", re, 8'h80);
        wr(8'h09, 8'h00); rd(8'h09, rb, re); check("R6 keep", rb, 8'h8A);

        // R7 masks
        wr(8'h51, 8'hFF); rd(8'h51, rb, re); check("R7 51 base", rb, 8'hC8);
        check("R7 51 enh", re, 8'hCC);
        wr(8'h53, 8'hFF); rd(8'h53, rb, re); check("R7 53", rb, 8'hC0);
        wr(8'h55, 8'h3F); rd(8'h55, rb, re); check("R7 55", rb, 8'h00);
        wr(8'h57, 8'hFF); rd(8'h57, rb, re); check("R7 57", rb, 8'hCC);

        // R8 class and subclass gating
        wr(8'h0B, 8'h07); rd(8'h0B, rb, re); check("R8 enh gated", re, 8'h01);
        wr(8'h4F, 8'h04); rd(8'h4F, rb, re); check("R8 base 4F", rb, 8'h00);
        wr(8'h0A, 8'h05); rd(8'h0A, rb, re); check("R8 enh open", re, 8'h05);
        check("R8 base ignored", rb, 8'h01);

        // R9 bus-master windows
        @(negedge clk); addr_i = 8'h71; wdata_i = 8'hFF; wr_i = 1'b1; #2;
        check("R9 we ch0", bm_we_b, 2'b01); check("R9 off", bm_off_b, 1);
        check("R9 base mask", bm_wd_b, 8'h03); check("R9 enh data", bm_wd_e, 8'hFF);
        addr_i = 8'h7A; wdata_i = 8'h5C; #2;
        check("R9 we ch1", bm_we_b, 2'b10); check("R9 off2", bm_off_b, 2);
        check("R9 data", bm_wd_b, 8'h5C);
        @(posedge clk); #1 wr_i = 1'b0;
        rd(8'h73, rb, re); check("R9 rd ch0", rb, 8'hA5);
        rd(8'h7F, rb, re); check("R9 rd ch1", rb, 8'h5A);

        // R10 other functions
        rd(8'h00, rb, re, 1); check("R10 rd", rb, 8'hFF);
        wr(8'h04, 8'hFF, 2); rd(8'h04, rb, re); check("R10 no write", rb, 8'h00);

        // R11 unimplemented bytes
        wr(8'h40, 8'hFF); rd(8'h40, rb, re); check("R11 0x40", rb, 8'h00);
        wr(8'hFF, 8'hFF); rd(8'hFF, rb, re); check("R11 0xFF", rb, 8'h00);

        check_space("R1 R11 final");
        live = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule